// File: doc/BRIEF.md
# Two-Bank SDRAM Command Timing Guard

This block sits in front of the command pins of a two-bank SDRAM and decides, in the same cycle, whether the command that a scheduler presents may be issued. It reads the command as chip-select, row strobe, column strobe and write-enable levels, plus a bank select bit, the A10 bit and the row address. It answers with a permit flag and a reason code that names the rule that blocked the command. It assumes that every permitted command is issued at the next rising edge, and it updates its own record of both banks on that edge: which bank is open, which row it holds, and how many cycles have passed since each timing event.

Each bank carries saturating cycle counters for its row-to-column delay, minimum open time, precharge recovery, row cycle time and write recovery. A single shared counter enforces spacing between activates to different banks. A read or write with A10 high puts the bank into a self-closing state: once the burst, the write recovery and the minimum open time have all elapsed, the bank returns to idle without a separate command. A bank held open past a maximum time raises a flag. All delays are parameters given in clock cycles. The defaults are a 7 ns clock at CAS latency 3 and a burst of four.

Top module: `sdr2b_guard`

## Requirements
- R1: When cs_n is low, {ras_n,cas_n,we_n} decodes as: activate 011, read 101, write 100, precharge 010 (one bank if a10=0, both banks if a10=1, with ba ignored), refresh 001, mode set 000. A cs_n high, 111 or 110 is always permitted and changes no state. ba=0 selects bank A and ba=1 selects bank B.
- R2: A read or write to an idle bank is blocked with code 1. To an open bank it is blocked with code 4 until at least T_RCD (3) cycles have passed since that bank's activate.
- R3: A precharge to an open bank is blocked with code 5 until T_RAS (7) cycles have passed since its activate. A precharge to an idle bank is permitted and has no effect.
- R4: An activate to an open bank is blocked with code 2. It is blocked with code 7 until T_RP (3) cycles have passed since the bank closed, and with code 8 until T_RC (10) cycles have passed since the bank's previous activate.
- R5: An activate is blocked with code 9 when the previous activate to either bank was fewer than T_RRD (2) cycles ago.
- R6: A precharge to a bank written at cycle w is blocked with code 6 before cycle w+BURST-1+T_WR (T_WR defaults to 1 and may be 2).
- R7: A read with a10=1 closes its bank at cycle max(issue+BURST, act+T_RAS, last write+BURST-1+T_WR). A write with a10=1 uses issue+BURST-1+T_WR as its first term. Until the bank closes, every command to it is blocked with code 3. The bank may be activated again T_RP cycles after it closes.
- R8: Precharge of both banks is permitted only when the single-bank precharge rules hold for each bank. When both fail, bank A's code is reported. It closes every open bank.
- R9: Refresh and mode set are blocked with code 10 unless both banks are idle and each has finished T_RP.
- R10: ras_over[b] is high while bank b is open and at least T_RAS_MAX (14286) cycles have passed since its activate.
- R11: cmd_ok is high exactly when why_code is 0. When several rules fail, the code is the first one in this order: 3, then 1 or 2, then 4, 5, 6, 7, 8, 9.
- R12: After reset, both banks are idle, ras_over is 0, and an activate to either bank is permitted at once.
- R13: row_a and row_b hold the row address captured by the last permitted activate to each bank, and 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select of the requested command, active low |
| ras_n | input | 1 | Row strobe level of the request |
| cas_n | input | 1 | Column strobe level of the request |
| we_n | input | 1 | Write-enable level of the request |
| ba | input | 1 | Bank select: 0 is bank A, 1 is bank B |
| a10 | input | 1 | Auto-close on read or write; both banks on precharge |
| row_addr | input | ROW_W | Row address for an activate |
| cmd_ok | output | 1 | The request may be issued at the next edge |
| why_code | output | 4 | Blocking reason, 0 when permitted |
| bank_active | output | 2 | Bank open (including self-closing), bit 0 is bank A |
| row_a | output | ROW_W | Open row of bank A |
| row_b | output | ROW_W | Open row of bank B |
| ras_over | output | 2 | Maximum open time reached, per bank |

## Verification
A counter that is off by one, or a bank state that is wrong, changes why_code or cmd_ok in the very first cycle a command tests the affected rule. So every command is compared, on the cycle it is presented, with a time-stamp model of both banks. If a bank closes too early or too late after a self-closing access, this shows up on bank_active on the following cycle, and on the code of the next activate or refresh. A wrong open-time counter shows up as ras_over rising one cycle too early or too late, during a long directed idle stretch.

// File: rtl/sdr2b_pkg.sv
`timescale 1ns/1ps
package sdr2b_pkg;

  typedef enum logic [2:0] {
    K_NOP, K_ACT, K_RD, K_WR, K_PRE, K_PALL, K_REF, K_MRS
  } cmd_e;

  typedef enum logic [1:0] {
    S_IDLE, S_OPEN, S_AUTO
  } bank_st_e;

  typedef enum logic [3:0] {
    Y_OK     = 4'd0,
    Y_CLOSED = 4'd1,
    Y_OPEN   = 4'd2,
    Y_AUTO   = 4'd3,
    Y_RCD    = 4'd4,
    Y_RAS    = 4'd5,
    Y_WREC   = 4'd6,
    Y_RP     = 4'd7,
    Y_RC     = 4'd8,
    Y_RRD    = 4'd9,
    Y_BUSY   = 4'd10
  } why_e;

endpackage

// File: rtl/sdr2b_decode.sv
`timescale 1ns/1ps
module sdr2b_decode
  import sdr2b_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10,
  output cmd_e cmd
);

  always_comb begin
    cmd = K_NOP;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = K_ACT;
        3'b101:  cmd = K_RD;
        3'b100:  cmd = K_WR;
        3'b010:  cmd = a10 ? K_PALL : K_PRE;
        3'b001:  cmd = K_REF;
        3'b000:  cmd = K_MRS;
        default: cmd = K_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdr2b_bank.sv
`timescale 1ns/1ps
module sdr2b_bank
  import sdr2b_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 7,
  parameter int T_RP      = 3,
  parameter int T_RC      = 10,
  parameter int T_WR      = 1,
  parameter int BURST     = 4,
  parameter int T_RAS_MAX = 14286,
  parameter int ROW_W     = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_act,
  input  logic             do_rd,
  input  logic             do_wr,
  input  logic             do_pre,
  input  logic             ap,
  input  logic [ROW_W-1:0] row_in,
  output bank_st_e         st,
  output logic             rcd_ok,
  output logic             ras_ok,
  output logic             rp_ok,
  output logic             rc_ok,
  output logic             wr_ok,
  output logic             ras_over,
  output logic [ROW_W-1:0] row_q
);

  localparam int CNT_W  = $clog2(T_RAS_MAX + 1);
  localparam int HOLD_W = $clog2(BURST + T_WR + 1);
  localparam logic [CNT_W-1:0]  CMAX    = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0]  CONE    = CNT_W'(1);
  localparam logic [HOLD_W-1:0] RD_LOAD = HOLD_W'(BURST - 1);
  localparam logic [HOLD_W-1:0] WR_LOAD = HOLD_W'(BURST - 2 + T_WR);

  bank_st_e          st_q, st_d;
  logic [CNT_W-1:0]  act_cnt_q, act_cnt_d;
  logic [CNT_W-1:0]  pre_cnt_q, pre_cnt_d;
  logic [HOLD_W-1:0] wr_hold_q, wr_hold_d;
  logic [HOLD_W-1:0] ap_cnt_q, ap_cnt_d;
  logic              close_now;
  logic              row_en;

  assign rcd_ok   = act_cnt_q >= CNT_W'(T_RCD);
  assign ras_ok   = act_cnt_q >= CNT_W'(T_RAS);
  assign rc_ok    = act_cnt_q >= CNT_W'(T_RC);
  assign rp_ok    = pre_cnt_q >= CNT_W'(T_RP);
  assign wr_ok    = (wr_hold_q == '0);
  assign ras_over = (st_q != S_IDLE) && (act_cnt_q >= CNT_W'(T_RAS_MAX));
  assign st       = st_q;
  assign row_en   = do_act;

  // internal closing point of a self-closing bank
  assign close_now = (st_q == S_AUTO) && (ap_cnt_q == '0) && ras_ok && wr_ok;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:  if (do_act) st_d = S_OPEN;
      S_OPEN: begin
        if (do_pre)                      st_d = S_IDLE;
        else if ((do_rd || do_wr) && ap) st_d = S_AUTO;
      end
      S_AUTO:  if (close_now) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase

    if (do_act)                 act_cnt_d = CONE;
    else if (act_cnt_q != CMAX) act_cnt_d = act_cnt_q + CONE;
    else                        act_cnt_d = act_cnt_q;

    if (do_pre || close_now)    pre_cnt_d = CONE;
    else if (pre_cnt_q != CMAX) pre_cnt_d = pre_cnt_q + CONE;
    else                        pre_cnt_d = pre_cnt_q;

    if (do_wr)                  wr_hold_d = WR_LOAD;
    else if (wr_hold_q != '0)   wr_hold_d = wr_hold_q - HOLD_W'(1);
    else                        wr_hold_d = wr_hold_q;

    if (do_rd && ap)            ap_cnt_d = RD_LOAD;
    else if (do_wr && ap)       ap_cnt_d = WR_LOAD;
    else if (ap_cnt_q != '0)    ap_cnt_d = ap_cnt_q - HOLD_W'(1);
    else                        ap_cnt_d = ap_cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      act_cnt_q <= CMAX;
      pre_cnt_q <= CMAX;
      wr_hold_q <= '0;
      ap_cnt_q  <= '0;
    end else begin
      st_q      <= st_d;
      act_cnt_q <= act_cnt_d;
      pre_cnt_q <= pre_cnt_d;
      wr_hold_q <= wr_hold_d;
      ap_cnt_q  <= ap_cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      row_q <= '0;
    else if (row_en) row_q <= row_in;
  end

  assert_act_from_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    do_act |-> (st_q == S_IDLE) && rp_ok && rc_ok);

  assert_col_after_rcd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rd || do_wr) |-> (st_q == S_OPEN) && rcd_ok);

  assert_pre_rules_R3: assert property (@(posedge clk) disable iff (!rst_n)
    do_pre |-> ras_ok && wr_ok);

  assert_auto_no_reopen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_AUTO) |=> (st_q != S_OPEN));

  assert_open_after_act_R13: assert property (@(posedge clk) disable iff (!rst_n)
    do_act |=> (st_q == S_OPEN) && (row_q == $past(row_in)));

endmodule

// File: rtl/sdr2b_guard.sv
`timescale 1ns/1ps
module sdr2b_guard
  import sdr2b_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 7,
  parameter int T_RP      = 3,
  parameter int T_RC      = 10,
  parameter int T_RRD     = 2,
  parameter int T_WR      = 1,
  parameter int BURST     = 4,
  parameter int T_RAS_MAX = 14286,
  parameter int ROW_W     = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             ba,
  input  logic             a10,
  input  logic [ROW_W-1:0] row_addr,
  output logic             cmd_ok,
  output logic [3:0]       why_code,
  output logic [1:0]       bank_active,
  output logic [ROW_W-1:0] row_a,
  output logic [ROW_W-1:0] row_b,
  output logic [1:0]       ras_over
);

  localparam int NB    = 2;
  localparam int RRD_W = $clog2(T_RRD + 1);
  localparam logic [RRD_W-1:0] RRD_LIM = RRD_W'(T_RRD);

  cmd_e             cmd;
  why_e             why;
  bank_st_e         st       [NB];
  logic             rcd_ok   [NB];
  logic             ras_ok   [NB];
  logic             rp_ok    [NB];
  logic             rc_ok    [NB];
  logic             wr_ok    [NB];
  logic             over_b   [NB];
  logic [ROW_W-1:0] row_q    [NB];
  logic [RRD_W-1:0] rrd_q, rrd_d;
  logic             rrd_ok;

  sdr2b_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .a10   (a10),
    .cmd   (cmd)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic hit;
    assign hit = (ba == 1'(b));
    sdr2b_bank #(
      .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RC(T_RC),
      .T_WR(T_WR), .BURST(BURST), .T_RAS_MAX(T_RAS_MAX), .ROW_W(ROW_W)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .do_act   (cmd_ok && (cmd == K_ACT) && hit),
      .do_rd    (cmd_ok && (cmd == K_RD) && hit),
      .do_wr    (cmd_ok && (cmd == K_WR) && hit),
      .do_pre   (cmd_ok && (st[b] == S_OPEN) &&
                 (((cmd == K_PRE) && hit) || (cmd == K_PALL))),
      .ap       (a10),
      .row_in   (row_addr),
      .st       (st[b]),
      .rcd_ok   (rcd_ok[b]),
      .ras_ok   (ras_ok[b]),
      .rp_ok    (rp_ok[b]),
      .rc_ok    (rc_ok[b]),
      .wr_ok    (wr_ok[b]),
      .ras_over (over_b[b]),
      .row_q    (row_q[b])
    );
    assign bank_active[b] = (st[b] != S_IDLE);
    assign ras_over[b]    = over_b[b];
  end

  assign row_a = row_q[0];
  assign row_b = row_q[1];

  function automatic why_e pre_why(bank_st_e s, logic ras_done, logic wr_done);
    if (s == S_AUTO)                 return Y_AUTO;
    if ((s == S_OPEN) && !ras_done)  return Y_RAS;
    if ((s == S_OPEN) && !wr_done)   return Y_WREC;
    return Y_OK;
  endfunction

  assign rrd_ok = (rrd_q >= RRD_LIM);

  always_comb begin
    why = Y_OK;
    case (cmd)
      K_ACT: begin
        if (st[ba] == S_AUTO)      why = Y_AUTO;
        else if (st[ba] == S_OPEN) why = Y_OPEN;
        else if (!rp_ok[ba])       why = Y_RP;
        else if (!rc_ok[ba])       why = Y_RC;
        else if (!rrd_ok)          why = Y_RRD;
      end
      K_RD, K_WR: begin
        if (st[ba] == S_AUTO)      why = Y_AUTO;
        else if (st[ba] == S_IDLE) why = Y_CLOSED;
        else if (!rcd_ok[ba])      why = Y_RCD;
      end
      K_PRE:  why = pre_why(st[ba], ras_ok[ba], wr_ok[ba]);
      K_PALL: begin
        why = pre_why(st[0], ras_ok[0], wr_ok[0]);
        if (why == Y_OK) why = pre_why(st[1], ras_ok[1], wr_ok[1]);
      end
      K_REF, K_MRS: begin
        if ((st[0] != S_IDLE) || (st[1] != S_IDLE) || !rp_ok[0] || !rp_ok[1])
          why = Y_BUSY;
      end
      default: why = Y_OK;
    endcase
  end

  assign cmd_ok   = (why == Y_OK);
  assign why_code = why;

  always_comb begin
    if (cmd_ok && (cmd == K_ACT)) rrd_d = RRD_W'(1);
    else if (!rrd_ok)             rrd_d = rrd_q + RRD_W'(1);
    else                          rrd_d = rrd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rrd_q <= RRD_LIM;
    else        rrd_q <= rrd_d;
  end

  assert_act_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && (cmd == K_ACT)) |=> !rrd_ok);

  assert_refresh_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && ((cmd == K_REF) || (cmd == K_MRS))) |-> (bank_active == 2'b00));

  assert_pall_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && (cmd == K_PALL)) |=> (bank_active == 2'b00));

  assert_over_only_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_over != 2'b00) |-> ((ras_over & ~bank_active) == 2'b00));

endmodule

// File: tb/sdr2b_guard_tb.sv
`timescale 1ns/1ps
module sdr2b_guard_tb_top;

  localparam int T_RCD = 3, T_RAS = 7, T_RP = 3, T_RC = 10, T_RRD = 2;
  localparam int T_WR = 1, BL = 4, T_RAS_MAX = 14286;
  localparam int DES = 0, NOP = 1, ACT = 2, RD = 3, WR = 4, PRE = 5,
                 PALL = 6, REF = 7, MRS = 8, BST = 9;
  localparam int FAR = -1000000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, ras_n, cas_n, we_n, ba, a10;
  logic [10:0] row_addr;
  logic        cmd_ok;
  logic [3:0]  why_code;
  logic [1:0]  bank_active, ras_over;
  logic [10:0] row_a, row_b;

  always #2.5 clk = ~clk;

  sdr2b_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .row_addr(row_addr), .cmd_ok(cmd_ok),
    .why_code(why_code), .bank_active(bank_active), .row_a(row_a),
    .row_b(row_b), .ras_over(ras_over)
  );

  int checks = 0, fails = 0, cyc = 0;
  int last_why;
  bit openb [2], autob [2];
  int act_t [2], close_t [2], wr_t [2], pclose [2];
  int last_act;
  logic [10:0] rowm [2];

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int pre_bank(int b, int c);
    if (autob[b]) return 3;
    if (openb[b] && (c - act_t[b] < T_RAS)) return 5;
    if (openb[b] && (c - wr_t[b] < BL - 1 + T_WR)) return 6;
    return 0;
  endfunction

  function automatic int exp_why(int k, int b, int c);
    int w;
    case (k)
      ACT: begin
        if (autob[b]) return 3;
        if (openb[b]) return 2;
        if (c - close_t[b] < T_RP) return 7;
        if (c - act_t[b] < T_RC) return 8;
        if (c - last_act < T_RRD) return 9;
        return 0;
      end
      RD, WR: begin
        if (autob[b]) return 3;
        if (!openb[b]) return 1;
        if (c - act_t[b] < T_RCD) return 4;
        return 0;
      end
      PRE: return pre_bank(b, c);
      PALL: begin
        w = pre_bank(0, c);
        if (w == 0) w = pre_bank(1, c);
        return w;
      end
      REF, MRS: begin
        if (openb[0] || openb[1] || (c - close_t[0] < T_RP) || (c - close_t[1] < T_RP))
          return 10;
        return 0;
      end
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int k, int code);
    if (k == DES || k == NOP || k == BST) return "R1";
    if (k == PALL) return "R8";
    case (code)
      1, 4:    return "R2";
      5:       return "R3";
      2, 7, 8: return "R4";
      9:       return "R5";
      6:       return "R6";
      3:       return "R7";
      10:      return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic settle(int c);
    for (int b = 0; b < 2; b++)
      if (autob[b] && c > pclose[b]) begin
        autob[b] = 0; openb[b] = 0; close_t[b] = pclose[b];
      end
  endtask

  task automatic apply(int k, int b, bit ap, logic [10:0] r, int c);
    case (k)
      ACT: begin openb[b] = 1; act_t[b] = c; last_act = c; rowm[b] = r; end
      RD, WR: begin
        if (k == WR) wr_t[b] = c;
        if (ap) begin
          autob[b] = 1;
          pclose[b] = imax(c + ((k == RD) ? BL : BL - 1 + T_WR), act_t[b] + T_RAS);
          pclose[b] = imax(pclose[b], wr_t[b] + BL - 1 + T_WR);
        end
      end
      PRE: if (openb[b]) begin openb[b] = 0; close_t[b] = c; end
      PALL: for (int i = 0; i < 2; i++)
              if (openb[i]) begin openb[i] = 0; close_t[i] = c; end
      default: ;
    endcase
  endtask

  task automatic drive(int k, bit b, bit ap, logic [10:0] r);
    logic [3:0] p;
    case (k)
      DES: p = 4'b1000;  NOP: p = 4'b0111;  ACT: p = 4'b0011;
      RD:  p = 4'b0101;  WR:  p = 4'b0100;  PRE: p = 4'b0010;
      PALL: p = 4'b0010; REF: p = 4'b0001;  MRS: p = 4'b0000;
      default: p = 4'b0110;
    endcase
    {cs_n, ras_n, cas_n, we_n} = p;
    ba = b;
    a10 = (k == PALL) ? 1'b1 : (k == PRE) ? 1'b0 : ap;
    row_addr = r;
  endtask

  task automatic step(int k, bit b, bit ap, logic [10:0] r);
    int ew;
    logic [1:0] eact, eover;
    string t;
    @(negedge clk);
    drive(k, b, ap, r);
    #1;
    settle(cyc);
    ew = exp_why(k, b, cyc);
    eact = {openb[1], openb[0]};
    eover = {openb[1] && (cyc - act_t[1] >= T_RAS_MAX), openb[0] && (cyc - act_t[0] >= T_RAS_MAX)};
    checks++;
    if (int'(why_code) != ew || cmd_ok != (ew == 0) || bank_active != eact ||
        row_a != rowm[0] || row_b != rowm[1] || ras_over != eover) begin
      fails++;
      if (row_a != rowm[0] || row_b != rowm[1]) t = "R13";
      else if (ras_over != eover) t = "R10";
      else t = tag_of(k, imax(ew, int'(why_code)));
      $display("FAIL %s cyc=%0d cmd=%0d ba=%0d: code=%0d ok=%0d act=%b over=%b rows=%h/%h expected code=%0d act=%b over=%b rows=%h/%h",
               t, cyc, k, b, why_code, cmd_ok, bank_active, ras_over, row_a, row_b,
               ew, eact, eover, rowm[0], rowm[1]);
    end
    last_why = int'(why_code);
    if (ew == 0) apply(k, b, ap, r, cyc);
    cyc++;
  endtask

  task automatic lit(int expw, string t);
    checks++;
    if (last_why != expw) begin
      fails++;
      $display("FAIL %s directed: code=%0d expected %0d", t, last_why, expw);
    end
  endtask

  task automatic nops(int n);
    for (int i = 0; i < n; i++) step(NOP, 0, 0, 11'h0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 190000);
    fails++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    for (int b = 0; b < 2; b++) begin
      openb[b] = 0; autob[b] = 0; act_t[b] = FAR; close_t[b] = FAR;
      wr_t[b] = FAR; pclose[b] = FAR; rowm[b] = '0;
    end
    last_act = FAR;
    drive(DES, 0, 0, 11'h0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12: reset state, immediate activate permitted
    step(NOP, 0, 0, 11'h0);
    checks++;
    if (bank_active != 2'b00 || ras_over != 2'b00 || !cmd_ok) begin
      fails++;
      $display("FAIL R12 reset: act=%b over=%b ok=%b expected 00 00 1", bank_active, ras_over, cmd_ok);
    end
    step(ACT, 0, 0, 11'h155); lit(0, "R12");
    step(ACT, 1, 0, 11'h0AA); lit(9, "R5");
    step(RD, 0, 0, 11'h0);    lit(4, "R2");
    step(RD, 0, 0, 11'h0);    lit(0, "R2");
    step(WR, 0, 0, 11'h0);    lit(0, "R2");
    step(PRE, 0, 0, 11'h0);   lit(5, "R3");
    nops(1);
    step(PRE, 0, 0, 11'h0);   lit(6, "R6");
    step(PRE, 0, 0, 11'h0);   lit(0, "R3");
    step(ACT, 0, 0, 11'h003); lit(7, "R4");
    nops(1);
    step(ACT, 0, 0, 11'h003); lit(0, "R4");
    step(REF, 0, 0, 11'h0);   lit(10, "R9");
    step(RD, 1, 0, 11'h0);    lit(1, "R2");
    step(RD, 0, 1, 11'h0);    lit(0, "R7");
    step(RD, 0, 0, 11'h0);    lit(3, "R7");
    nops(4);
    step(ACT, 0, 0, 11'h02A); lit(7, "R7");
    step(ACT, 0, 0, 11'h02A); lit(0, "R7");
    nops(1);
    step(ACT, 1, 0, 11'h7FF); lit(0, "R5");
    step(ACT, 1, 0, 11'h111); lit(2, "R4");
    nops(5);
    step(PALL, 0, 0, 11'h0);  lit(0, "R8");
    nops(2);
    step(REF, 0, 0, 11'h0);   lit(0, "R9");
    step(MRS, 0, 0, 11'h0);   lit(0, "R9");
    step(BST, 0, 0, 11'h0);   lit(0, "R1");
    step(DES, 1, 1, 11'h0);   lit(0, "R1");

    // R10: hold bank B open past the maximum open time
    step(ACT, 1, 0, 11'h321);
    nops(T_RAS_MAX + 2);
    checks++;
    if (ras_over != 2'b10) begin
      fails++;
      $display("FAIL R10 long open: over=%b expected 10", ras_over);
    end
    step(PRE, 1, 0, 11'h0);

    // constrained random mix, R11 priority checked on every step
    void'($urandom(32'd2024));
    for (int i = 0; i < 4000; i++) begin
      int r, k;
      r = int'($urandom % 100);
      if (r < 8) k = DES; else if (r < 20) k = NOP; else if (r < 38) k = ACT;
      else if (r < 55) k = RD; else if (r < 70) k = WR; else if (r < 80) k = PRE;
      else if (r < 85) k = PALL; else if (r < 90) k = REF; else if (r < 93) k = MRS;
      else k = BST;
      step(k, 1'($urandom % 2), ($urandom % 4) == 0, 11'($urandom));
    end
    finish_run();
  end

endmodule